// File: doc/BRIEF.md
# Serial Channel Command and Status Unit

This block holds the control side of every channel in a multi-channel serial controller. Channels come in pairs, and each pair forms a block that shares one interrupt status word. A byte-wide register bus reaches the unit. The unit decodes each bus address into a channel and a register, and keeps each channel's two mode bytes, its receiver enable and its 8-bit status word. It carries out command-register writes and passes bytes written to the transmit holding register on to a byte-out strobe port, but only while that channel's transmitter is ready.

The interrupt status words themselves sit outside this unit. The unit drives one-cycle set and clear strobes into them, one bit position per source. The receive datapath sits beside the unit. It reports arriving characters and their error flags, and it reports when a channel's receive data has been drained. It takes back a receiver-enable level and a flush strobe. Writes to the baud-rate select, auxiliary control, interrupt mask and output configuration registers are accepted and change nothing here.

Top module: `uart_cmd_stat`

## Requirements
- R1: The register offset is `bus_addr[4:0] ^ 1` and the channel is `bus_addr[ADDR_W-1:4]`, so bit 4 of the offset picks the odd channel of a pair. Per-channel registers sit at offset low nibble 1 (mode), 3 (status read, clock select write), 5 (command) and 7 (holding). An access reaches only the addressed channel.
- R2: After reset `bus_rdata`, `tx_valid`, `rx_en`, `rx_flush`, `isr_set` and `isr_clr` are all zero, every status word is 0x00, both mode bytes are 0x00 and the mode pointer selects the first byte.
- R3: A mode read or write uses the byte the pointer selects and then points the pointer at the second byte, where it stays. Command code 1 (upper nibble) returns it to the first byte.
- R4: Command bit 2 sets status TXRDY (bit 2) and TXEMT (bit 3) and pulses the channel's TX interrupt set strobe. Command bit 3 clears both and pulses the TX clear strobe. When both bits are set, the disable wins. Interrupt bit index = 8*block + 4*(channel odd) + {0 TX, 1 RX, 2 break}.
- R5: Command bit 0 enables the receiver and bit 1 disables it. When both are set, the receiver ends up disabled. `rx_en` shows the state.
- R6: Command code 2 disables the receiver, clears RXRDY (bit 0), pulses `rx_flush` and pulses the RX clear strobe. The error bits are kept.
- R7: Command code 3 clears TXRDY and TXEMT and pulses the TX clear strobe.
- R8: Command code 4 clears status bits 7..4 (overrun, parity, framing, break).
- R9: Command code 5 from either channel of a block pulses the clear strobe on both break positions (bits 2 and 6) of that block.
- R10: A holding-register write produces one `tx_valid` pulse carrying the channel and byte on the next cycle, only if TXRDY is set. Otherwise the byte is dropped.
- R11: `rx_valid` is ignored while the receiver is disabled. When the receiver is enabled, `rx_err` bits 0..3 are ORed into status bits 4..7. RXRDY is set, and the RX set strobe pulses, only when RXRDY was clear. A break flag that is new to the channel pulses the break set strobe.
- R12: Command codes 6 to 15, the clock-select write and writes to offsets 0x09, 0x0B and 0x1B change no status, mode or strobe.
- R13: `rx_drained` clears RXRDY and, if RXRDY was set, pulses the RX clear strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| rx_valid | input | NUM_CH | Character arrived, per channel |
| rx_err | input | 4*NUM_CH | Overrun, parity, framing and break flags with the character |
| rx_drained | input | NUM_CH | Receive data emptied, per channel |
| rx_en | output | NUM_CH | Receiver enabled |
| rx_flush | output | NUM_CH | Discard pending receive data |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_chan | output | CH_W | Channel of the transmit byte |
| tx_data | output | 8 | Transmit byte |
| isr_set | output | 8*NUM_BLK | Interrupt status set strobes |
| isr_clr | output | 8*NUM_BLK | Interrupt status clear strobes |

## Verification
Some properties are checked on every cycle. TXRDY and TXEMT never disagree, a transmit strobe never appears unless TXRDY was set, and a flush always leaves the receiver disabled with RXRDY clear. Every rise of RXRDY or TXRDY comes with its set strobe, and RXRDY rises only while the receiver is enabled. The other behaviours need the bench's scenarios to show them: the mode-pointer sequence, disable winning over enable, break clears reaching the neighbour channel's position, error flags that survive a receiver reset, and the writes that must have no effect.

// File: rtl/uart_cs_pkg.sv
package uart_cs_pkg;

  typedef enum logic [2:0] {
    RK_NONE = 3'd0,
    RK_MODE = 3'd1,
    RK_STAT = 3'd2,
    RK_CMD  = 3'd3,
    RK_HOLD = 3'd4
  } reg_kind_e;

  // upper-nibble command codes
  localparam logic [3:0] CC_PTR_RST  = 4'd1;
  localparam logic [3:0] CC_RX_RST   = 4'd2;
  localparam logic [3:0] CC_TX_RST   = 4'd3;
  localparam logic [3:0] CC_ERR_RST  = 4'd4;
  localparam logic [3:0] CC_BRK_CLR  = 4'd5;

  // status bit positions
  localparam int SB_RXRDY = 0;
  localparam int SB_TXRDY = 2;
  localparam int SB_TXEMT = 3;
  localparam int SB_BRK   = 7;

  // strobe slot within a channel's interrupt nibble
  localparam int IS_TX  = 0;
  localparam int IS_RX  = 1;
  localparam int IS_BRK = 2;

endpackage

// File: rtl/uart_cs_decode.sv
module uart_cs_decode
  import uart_cs_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int ADDR_W = CH_W + 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [CH_W-1:0]   ch_idx,
  output reg_kind_e         kind
);

  logic [3:0] off_lo;

  always_comb begin
    off_lo = addr[3:0] ^ 4'h1;
    ch_idx = addr[ADDR_W-1:4];
    unique case (off_lo)
      4'h1:    kind = RK_MODE;
      4'h3:    kind = RK_STAT;
      4'h5:    kind = RK_CMD;
      4'h7:    kind = RK_HOLD;
      default: kind = RK_NONE;
    endcase
  end

endmodule

// File: rtl/uart_cs_chan.sv
module uart_cs_chan
  import uart_cs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  reg_kind_e  kind,
  input  logic [7:0] wdata,
  input  logic       rx_valid,
  input  logic [3:0] rx_err,
  input  logic       rx_drained,
  output logic [7:0] mode_rd,
  output logic [7:0] status,
  output logic       rx_en,
  output logic       rx_flush,
  output logic [2:0] set_stb,
  output logic [2:0] clr_stb,
  output logic       brk_clr_stb
);

  logic [7:0] mr0_q, mr1_q, mr0_d, mr1_d;
  logic       ptr_q, ptr_d;
  logic [7:0] sr_q, sr_d;
  logic       rxen_q, rxen_d;
  logic       flush_q, flush_d;
  logic [2:0] set_q, set_d, clr_q, clr_d;
  logic       bclr_q, bclr_d;
  logic       wr_hit, rd_hit;
  logic [3:0] code;

  assign wr_hit = sel & wr_en;
  assign rd_hit = sel & rd_en;
  assign code   = wdata[7:4];

  always_comb begin
    mr0_d   = mr0_q;
    mr1_d   = mr1_q;
    ptr_d   = ptr_q;
    sr_d    = sr_q;
    rxen_d  = rxen_q;
    flush_d = 1'b0;
    set_d   = '0;
    clr_d   = '0;
    bclr_d  = 1'b0;

    // receive datapath events: drain first, then arrival
    if (rx_drained) begin
      clr_d[IS_RX]   = sr_q[SB_RXRDY];
      sr_d[SB_RXRDY] = 1'b0;
    end
    if (rx_valid && rxen_q) begin
      if (!sr_d[SB_RXRDY]) begin
        sr_d[SB_RXRDY] = 1'b1;
        set_d[IS_RX]   = 1'b1;
        clr_d[IS_RX]   = 1'b0;
      end
      if (rx_err[3] && !sr_q[SB_BRK]) set_d[IS_BRK] = 1'b1;
      sr_d[7:4] = sr_d[7:4] | rx_err;
    end

    // bus access, applied after receive events
    if (rd_hit && kind == RK_MODE) ptr_d = 1'b1;
    if (wr_hit) begin
      unique case (kind)
        RK_MODE: begin
          if (ptr_q) mr1_d = wdata;
          else       mr0_d = wdata;
          ptr_d = 1'b1;
        end
        RK_CMD: begin
          if (wdata[0]) rxen_d = 1'b1;
          if (wdata[1]) rxen_d = 1'b0;
          if (wdata[2]) begin
            sr_d[SB_TXEMT:SB_TXRDY] = 2'b11;
            set_d[IS_TX] = 1'b1;
            clr_d[IS_TX] = 1'b0;
          end
          if (wdata[3]) begin
            sr_d[SB_TXEMT:SB_TXRDY] = 2'b00;
            set_d[IS_TX] = 1'b0;
            clr_d[IS_TX] = 1'b1;
          end
          unique case (code)
            CC_PTR_RST: ptr_d = 1'b0;
            CC_RX_RST: begin
              rxen_d         = 1'b0;
              sr_d[SB_RXRDY] = 1'b0;
              flush_d        = 1'b1;
              set_d[IS_RX]   = 1'b0;
              clr_d[IS_RX]   = 1'b1;
            end
            CC_TX_RST: begin
              sr_d[SB_TXEMT:SB_TXRDY] = 2'b00;
              set_d[IS_TX] = 1'b0;
              clr_d[IS_TX] = 1'b1;
            end
            CC_ERR_RST: sr_d[7:4] = 4'h0;
            CC_BRK_CLR: begin
              bclr_d        = 1'b1;
              set_d[IS_BRK] = 1'b0;
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr0_q   <= '0;
      mr1_q   <= '0;
      ptr_q   <= 1'b0;
      sr_q    <= '0;
      rxen_q  <= 1'b0;
      flush_q <= 1'b0;
      set_q   <= '0;
      clr_q   <= '0;
      bclr_q  <= 1'b0;
    end else begin
      mr0_q   <= mr0_d;
      mr1_q   <= mr1_d;
      ptr_q   <= ptr_d;
      sr_q    <= sr_d;
      rxen_q  <= rxen_d;
      flush_q <= flush_d;
      set_q   <= set_d;
      clr_q   <= clr_d;
      bclr_q  <= bclr_d;
    end
  end

  assign mode_rd     = ptr_q ? mr1_q : mr0_q;
  assign status      = sr_q;
  assign rx_en       = rxen_q;
  assign rx_flush    = flush_q;
  assign set_stb     = set_q;
  assign clr_stb     = clr_q;
  assign brk_clr_stb = bclr_q;

endmodule

// File: rtl/uart_cs_txport.sv
module uart_cs_txport #(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic [CH_W-1:0] fire_ch,
  input  logic [7:0]      fire_data,
  output logic            tx_valid,
  output logic [CH_W-1:0] tx_chan,
  output logic [7:0]      tx_data
);

  logic            vld_q, vld_d;
  logic [CH_W-1:0] ch_q, ch_d;
  logic [7:0]      dat_q, dat_d;

  always_comb begin
    vld_d = fire;
    ch_d  = ch_q;
    dat_d = dat_q;
    if (fire) begin
      ch_d  = fire_ch;
      dat_d = fire_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      ch_q  <= '0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      ch_q  <= ch_d;
      dat_q <= dat_d;
    end
  end

  assign tx_valid = vld_q;
  assign tx_chan  = ch_q;
  assign tx_data  = dat_q;

endmodule

// File: rtl/uart_cmd_stat.sv
module uart_cmd_stat
  import uart_cs_pkg::*;
#(
  parameter int NUM_CH   = 8,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int ADDR_W  = CH_W + 4,
  localparam int NUM_BLK = NUM_CH / 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  input  logic [NUM_CH-1:0]    rx_valid,
  input  logic [NUM_CH*4-1:0]  rx_err,
  input  logic [NUM_CH-1:0]    rx_drained,
  output logic [NUM_CH-1:0]    rx_en,
  output logic [NUM_CH-1:0]    rx_flush,
  output logic                 tx_valid,
  output logic [CH_W-1:0]      tx_chan,
  output logic [7:0]           tx_data,
  output logic [NUM_BLK*8-1:0] isr_set,
  output logic [NUM_BLK*8-1:0] isr_clr
);

  logic [CH_W-1:0] ch_idx;
  reg_kind_e       kind;
  logic [7:0]      ch_mode [NUM_CH];
  logic [7:0]      ch_stat [NUM_CH];
  logic [2:0]      ch_set  [NUM_CH];
  logic [2:0]      ch_clr  [NUM_CH];
  logic [NUM_CH-1:0] ch_bclr;
  logic [NUM_CH-1:0] rxrdy_v, txrdy_v, txemt_v;
  logic [7:0]      rdata_q, rdata_d;
  logic            tx_fire;

  uart_cs_decode #(.NUM_CH(NUM_CH)) dec_i (
    .addr   (bus_addr),
    .ch_idx (ch_idx),
    .kind   (kind)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    uart_cs_chan chan_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .sel         (ch_idx == CH_W'(c)),
      .wr_en       (bus_wr),
      .rd_en       (bus_rd),
      .kind        (kind),
      .wdata       (bus_wdata),
      .rx_valid    (rx_valid[c]),
      .rx_err      (rx_err[c*4 +: 4]),
      .rx_drained  (rx_drained[c]),
      .mode_rd     (ch_mode[c]),
      .status      (ch_stat[c]),
      .rx_en       (rx_en[c]),
      .rx_flush    (rx_flush[c]),
      .set_stb     (ch_set[c]),
      .clr_stb     (ch_clr[c]),
      .brk_clr_stb (ch_bclr[c])
    );
    assign rxrdy_v[c] = ch_stat[c][SB_RXRDY];
    assign txrdy_v[c] = ch_stat[c][SB_TXRDY];
    assign txemt_v[c] = ch_stat[c][SB_TXEMT];
  end

  // pair channels into blocks; a break clear from either side hits both
  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    logic       brk_any;
    logic [7:0] clr_w, set_w;
    always_comb begin
      brk_any = ch_bclr[2*b] | ch_bclr[2*b+1];
      clr_w = {1'b0, ch_clr[2*b+1][2] | brk_any, ch_clr[2*b+1][1:0],
               1'b0, ch_clr[2*b][2]   | brk_any, ch_clr[2*b][1:0]};
      set_w = {1'b0, ch_set[2*b+1], 1'b0, ch_set[2*b]} & ~clr_w;
    end
    assign isr_clr[b*8 +: 8] = clr_w;
    assign isr_set[b*8 +: 8] = set_w;
  end

  always_comb begin
    unique case (kind)
      RK_MODE: rdata_d = ch_mode[ch_idx];
      RK_STAT: rdata_d = ch_stat[ch_idx];
      default: rdata_d = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rdata_d;
  end
  assign bus_rdata = rdata_q;

  assign tx_fire = bus_wr && (kind == RK_HOLD) && txrdy_v[ch_idx];

  uart_cs_txport #(.CH_W(CH_W)) tx_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (tx_fire),
    .fire_ch   (ch_idx),
    .fire_data (bus_wdata),
    .tx_valid  (tx_valid),
    .tx_chan   (tx_chan),
    .tx_data   (tx_data)
  );

endmodule

// File: rtl/uart_cs_chk.sv
module uart_cs_chk #(
  parameter int NUM_CH   = 8,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int NUM_BLK = NUM_CH / 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tx_valid,
  input logic [CH_W-1:0]      tx_chan,
  input logic [NUM_CH-1:0]    rx_en,
  input logic [NUM_CH-1:0]    rx_flush,
  input logic [NUM_CH-1:0]    rxrdy_v,
  input logic [NUM_CH-1:0]    txrdy_v,
  input logic [NUM_CH-1:0]    txemt_v,
  input logic [NUM_BLK*8-1:0] isr_set
);

  logic [NUM_CH-1:0] txrdy_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) txrdy_prev <= '0;
    else        txrdy_prev <= txrdy_v;
  end

  AST_TX_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> txrdy_prev[tx_chan]); // R10

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    localparam int TXB = 8*(c/2) + 4*(c%2);
    localparam int RXB = TXB + 1;

    AST_TX_FLAGS_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
      txrdy_v[c] == txemt_v[c]); // R4

    AST_TXRDY_RISE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(txrdy_v[c]) |-> isr_set[TXB]); // R4

    AST_FLUSH_DROPS_RX: assert property (@(posedge clk) disable iff (!rst_n)
      rx_flush[c] |-> (!rx_en[c] && !rxrdy_v[c])); // R6

    AST_RXRDY_RISE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rxrdy_v[c]) |-> isr_set[RXB]); // R11

    AST_RXRDY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rxrdy_v[c]) |-> $past(rx_en[c])); // R11
  end

endmodule

bind uart_cmd_stat uart_cs_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_valid (tx_valid),
  .tx_chan  (tx_chan),
  .rx_en    (rx_en),
  .rx_flush (rx_flush),
  .rxrdy_v  (rxrdy_v),
  .txrdy_v  (txrdy_v),
  .txemt_v  (txemt_v),
  .isr_set  (isr_set)
);

// File: tb/uart_cmd_stat_tb_top.sv
module uart_cmd_stat_tb_top;

  localparam int NUM_CH = 8;
  localparam int CH_W   = 3;
  localparam int AW     = 7;
  localparam int NB     = 4;
  localparam int OF_MODE = 1, OF_STAT = 3, OF_CMD = 5, OF_HOLD = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_wr, bus_rd;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [NUM_CH-1:0] rx_valid, rx_drained, rx_en, rx_flush;
  logic [NUM_CH*4-1:0] rx_err;
  logic tx_valid;
  logic [CH_W-1:0] tx_chan;
  logic [7:0] tx_data;
  logic [NB*8-1:0] isr_set, isr_clr;

  uart_cmd_stat #(.NUM_CH(NUM_CH)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_err(rx_err), .rx_drained(rx_drained),
    .rx_en(rx_en), .rx_flush(rx_flush), .tx_valid(tx_valid),
    .tx_chan(tx_chan), .tx_data(tx_data), .isr_set(isr_set), .isr_clr(isr_clr)
  );

  always #4 clk = ~clk;

  int errs = 0;
  int checks = 0;

  logic [10:0] tx_q [$];
  logic [7:0]  rd_q [$];
  string       rd_tag_q [$];
  logic        rd_flag;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(input int ch, input int off);
    return AW'(((ch / 2) << 5) | ((((ch % 2) * 16) + off) ^ 1));
  endfunction

  function automatic logic [31:0] bm(input int ch, input int k);
    return 32'd1 << (8*(ch/2) + 4*(ch%2) + k);
  endfunction

  // monitor: pops the scoreboard as results appear
  always @(posedge clk) rd_flag <= bus_rd;
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_valid) begin
        if (tx_q.size() == 0) check(1'b0, "R10 unexpected tx", {21'd0, tx_chan, tx_data}, 32'd0);
        else begin
          logic [10:0] e;
          e = tx_q.pop_front();
          check({tx_chan, tx_data} == e, "R10 tx byte", {21'd0, tx_chan, tx_data}, {21'd0, e});
        end
      end
      if (rd_flag) begin
        logic [7:0] e;
        string t;
        e = rd_q.pop_front();
        t = rd_tag_q.pop_front();
        check(bus_rdata == e, t, {24'd0, bus_rdata}, {24'd0, e});
      end
    end
  end

  task automatic wr_addr(input logic [AW-1:0] a, input logic [7:0] d,
                         input logic [31:0] es, input logic [31:0] ec, input string tag);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check(isr_set == es, {tag, " set strobes"}, isr_set, es);
    check(isr_clr == ec, {tag, " clear strobes"}, isr_clr, ec);
  endtask

  task automatic wr(input int ch, input int off, input logic [7:0] d,
                    input logic [31:0] es, input logic [31:0] ec, input string tag);
    wr_addr(mk(ch, off), d, es, ec, tag);
  endtask

  task automatic rd(input int ch, input int off, input logic [7:0] e, input string tag);
    rd_q.push_back(e);
    rd_tag_q.push_back(tag);
    bus_addr = mk(ch, off); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rxe(input int ch, input logic [3:0] err, input bit drain,
                     input logic [31:0] es, input logic [31:0] ec, input string tag);
    rx_valid[ch] = !drain;
    rx_drained[ch] = drain;
    rx_err[ch*4 +: 4] = err;
    @(negedge clk);
    rx_valid = '0; rx_drained = '0; rx_err = '0;
    check(isr_set == es, {tag, " set strobes"}, isr_set, es);
    check(isr_clr == ec, {tag, " clear strobes"}, isr_clr, ec);
  endtask

  initial begin
    #(8 * 100000);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    rx_valid = '0; rx_drained = '0; rx_err = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    check(bus_rdata == 0 && !tx_valid, "R2 rdata/tx after reset", {23'd0, tx_valid, bus_rdata}, 0);
    check(rx_en == 0 && rx_flush == 0, "R2 rx outputs after reset", {16'd0, rx_en, rx_flush}, 0);
    check(isr_set == 0 && isr_clr == 0, "R2 strobes after reset", isr_set | isr_clr, 0);
    rd(0, OF_STAT, 8'h00, "R2 status after reset");
    rd(3, OF_MODE, 8'h00, "R2 mode after reset");

    // R10 holding write dropped while transmitter off
    wr(2, OF_HOLD, 8'h5A, 0, 0, "R10 drop");
    check(!tx_valid, "R10 no tx when not ready", {31'd0, tx_valid}, 0);

    // R4 enable transmitter, R10 forward
    wr(2, OF_CMD, 8'h04, bm(2, 0), 0, "R4 tx enable");
    rd(2, OF_STAT, 8'h0C, "R4 status after tx enable");
    tx_q.push_back({3'd2, 8'hA5});
    wr(2, OF_HOLD, 8'hA5, 0, 0, "R10 forward");

    // R1 odd channel addressing
    wr(3, OF_CMD, 8'h04, bm(3, 0), 0, "R1 odd channel cmd");
    tx_q.push_back({3'd3, 8'h3C});
    wr(3, OF_HOLD, 8'h3C, 0, 0, "R1 odd channel hold");
    rd(3, OF_STAT, 8'h0C, "R1 odd channel status");
    rd(1, OF_STAT, 8'h00, "R1 other channel untouched");

    // R4 disable wins
    wr(2, OF_CMD, 8'h0C, 0, bm(2, 0), "R4 enable+disable");
    rd(2, OF_STAT, 8'h00, "R4 status after disable wins");

    // R3 mode pointer
    wr(1, OF_MODE, 8'h11, 0, 0, "R3 mode w1");
    wr(1, OF_MODE, 8'h22, 0, 0, "R3 mode w2");
    wr(1, OF_MODE, 8'h33, 0, 0, "R3 mode w3");
    rd(1, OF_MODE, 8'h33, "R3 sticky second byte");
    wr(1, OF_CMD, 8'h10, 0, 0, "R3 pointer reset");
    rd(1, OF_MODE, 8'h11, "R3 first byte after reset");
    rd(1, OF_MODE, 8'h33, "R3 second byte after read");

    // R11 receive events
    rxe(5, 4'h1, 0, 0, 0, "R11 ignored while disabled");
    rd(5, OF_STAT, 8'h00, "R11 status unchanged while disabled");
    wr(5, OF_CMD, 8'h01, 0, 0, "R5 rx enable");
    check(rx_en == 8'h20, "R5 rx_en after enable", {24'd0, rx_en}, 32'h20);
    rxe(5, 4'h1, 0, bm(5, 1), 0, "R11 first char");
    rd(5, OF_STAT, 8'h11, "R11 status overrun+rxrdy");
    rxe(5, 4'h0, 0, 0, 0, "R11 second char no strobe");
    rxe(5, 4'h8, 0, bm(5, 2), 0, "R11 new break");
    rd(5, OF_STAT, 8'h91, "R11 status with break");

    // R8 reset errors
    wr(5, OF_CMD, 8'h40, 0, 0, "R8 reset errors");
    rd(5, OF_STAT, 8'h01, "R8 status after error reset");

    // R9 break clear from neighbour channel
    wr(4, OF_CMD, 8'h50, 0, (32'd1 << 18) | (32'd1 << 22), "R9 break clear both");

    // R13 drained
    rxe(5, 4'h0, 1, 0, bm(5, 1), "R13 drained");
    rd(5, OF_STAT, 8'h00, "R13 status after drain");
    rxe(5, 4'h2, 0, bm(5, 1), 0, "R11 char with parity");
    rd(5, OF_STAT, 8'h21, "R11 status parity+rxrdy");

    // R6 reset receiver
    wr(5, OF_CMD, 8'h20, 0, bm(5, 1), "R6 reset rx");
    check(rx_flush == 8'h20, "R6 flush strobe", {24'd0, rx_flush}, 32'h20);
    check(rx_en == 8'h00, "R6 rx disabled", {24'd0, rx_en}, 0);
    rd(5, OF_STAT, 8'h20, "R6 errors kept");

    // R5 disable wins
    wr(5, OF_CMD, 8'h03, 0, 0, "R5 enable+disable");
    check(rx_en == 8'h00, "R5 rx_en disable wins", {24'd0, rx_en}, 0);
    rxe(5, 4'h0, 0, 0, 0, "R5 char ignored");
    rd(5, OF_STAT, 8'h20, "R5 status unchanged");

    // R12 ignored writes and codes
    wr(0, OF_CMD, 8'h04, bm(0, 0), 0, "R12 setup tx enable");
    for (int k = 6; k < 16; k++) wr(0, OF_CMD, 8'(k << 4), 0, 0, "R12 ignored code");
    wr(0, OF_STAT, 8'hFF, 0, 0, "R12 clock select write");
    wr_addr(7'h08, 8'hFF, 0, 0, "R12 aux control write");
    wr_addr(7'h0A, 8'hFF, 0, 0, "R12 mask write");
    wr_addr(7'h1A, 8'hFF, 0, 0, "R12 output config write");
    rd(0, OF_STAT, 8'h0C, "R12 status unchanged");
    rd(0, OF_MODE, 8'h00, "R12 mode unchanged");

    // R7 reset transmitter
    wr(0, OF_CMD, 8'h30, 0, bm(0, 0), "R7 reset tx");
    rd(0, OF_STAT, 8'h00, "R7 status after reset tx");
    wr(0, OF_HOLD, 8'h77, 0, 0, "R7 hold dropped");

    repeat (2) @(negedge clk);
    check(tx_q.size() == 0, "R10 all tx bytes seen", tx_q.size(), 0);
    check(rd_q.size() == 0, "R3 all reads seen", rd_q.size(), 0);

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule